// File: doc/BRIEF.md
# Multi-Counter Performance Monitor

This block is a bank of event counters that observes a processor core. Each counter is 32 bits wide and has its own control and status words. A single global word switches all counting on or off. Event sources arrive as a flat vector of 16-bit groups. Each counter chooses one group and a 16-bit sub-event mask. It advances by one in every qualifying cycle in which at least one masked bit of that group is high.

A counter can instead be chained to its lower-numbered neighbour. In that mode it counts that neighbour's wraps, which builds wider counters. Counting is filtered by privilege: a per-counter threshold is compared with the current privilege level, and a separate bit allows or blocks cycles spent in kernel mode. When a counter wraps from all ones to zero, it latches an overflow flag. If its interrupt enable is set, it also latches an interrupt flag, and the shared interrupt line is the OR of those flags.

Software uses the counters for sampling. It preloads the negative of the remaining event count so that the wrap comes after that many events. It clears the status flags by writing back the word it read. The register bus is plain: address, write enable, write data and read data. Writes take effect at the clock edge. Reads are combinational and always accepted, so the bus has no valid/ready handshake and no back-pressure.

Top module: `pmu_top`

## Requirements
- R1: Byte addresses are decoded exactly. The global word is at 0x1000. For counter i, the value is at 0x1080+4i, the control word at 0x1100+4i and the status word at 0x1180+4i. Any other address, including one that is not word-aligned, reads 0 and ignores writes. All registers reset to 0.
- R2: Global bit 0 is the master enable, and it reads back in bit 0 with all other bits 0. While it is clear, no counter value changes except through a software write.
- R3: The control word has these fields: bit 0 interrupt enable, bit 3 kernel count enable, bits 7:4 privilege threshold, bits 12:8 group select and bits 31:16 sub-event mask. A read returns the written fields, with bits 2:1 and 15:13 reading 0.
- R4: The counter may be enabled in a cycle and have a select other than 1. It then increments by exactly 1 when (events_i[16g+15:16g] AND mask) is nonzero, where g is the select value. A select of NUM_GROUPS or more never counts.
- R5: A counter counts only in a cycle where priv_lvl_i is at or below its threshold field. While kernel_mode_i is high it also needs control bit 3.
- R6: When an increment wraps the value from 0xFFFFFFFF to 0, status bit 0 is set. Status bit 4 is also set if control bit 0 was set in that cycle. The other status bits read 0.
- R7: With select 1, counter i increments once in each cycle in which counter i−1 wraps, in that same cycle. The master enable and the privilege filter still apply, and the mask is ignored. Counter 0 never counts with select 1.
- R8: Writing 1 to status bit 0 or bit 4 clears that bit, and writing 0 leaves it unchanged. If a wrap sets a bit in the same cycle as a write that clears it, the set wins.
- R9: irq_o is high exactly when some counter has status bit 4 set.
- R10: A value write in the same cycle as an increment wins, and that cycle produces no wrap. A read returns the state before the current cycle's update.
- R11: An all-zero control word stops the counter, and its value and status are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| events_i | input | NUM_GROUPS*16 | Event groups, group g at bits 16g+15:16g |
| priv_lvl_i | input | 4 | Current privilege level |
| kernel_mode_i | input | 1 | High while the core runs in kernel mode |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first is a wrap that sets a status flag while software writes 1 to clear that same flag. The second is a software write to a counter value while an event would increment it, and possibly wrap it as well as its chained neighbour. Both are provoked by preloading a counter just below the wrap with events held high. The status write or the value write is then issued at the cycle where the wrap lands, and random traffic repeats the situation many more times. A behavioural model in the bench decides the outcome every cycle: the set wins over the clear, and the write wins over the increment. The bench compares that outcome with the read data and the interrupt line.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W = 32;
  localparam int MASK_W = 16;
  localparam int SEL_W  = 5;
  localparam int LVL_W  = 4;

  localparam logic [15:0] GLB_OFS  = 16'h1000;
  localparam logic [15:0] VAL_BASE = 16'h1080;
  localparam logic [15:0] CTL_BASE = 16'h1100;
  localparam logic [15:0] STA_BASE = 16'h1180;

  localparam logic [SEL_W-1:0] SEL_CHAIN = 5'd1;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic [SEL_W-1:0]  sel;
    logic [LVL_W-1:0]  thresh;
    logic              kern_ok;
    logic              int_en;
  } ctl_t;

  function automatic ctl_t word_to_ctl(input logic [DATA_W-1:0] w);
    ctl_t c;
    c.mask    = w[31:16];
    c.sel     = w[12:8];
    c.thresh  = w[7:4];
    c.kern_ok = w[3];
    c.int_en  = w[0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctl_to_word(input ctl_t c);
    return {c.mask, 3'b000, c.sel, c.thresh, c.kern_ok, 2'b00, c.int_en};
  endfunction
endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
  import pmu_pkg::*;
#(
  parameter int NUM_GROUPS = 16
) (
  input  logic [NUM_GROUPS*MASK_W-1:0] events,
  input  logic [SEL_W-1:0]             sel,
  input  logic [MASK_W-1:0]            mask,
  output logic                         hit
);
  logic [NUM_GROUPS-1:0] grp_hit;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    if (g == 1) begin : g_chain_slot
      assign grp_hit[g] = 1'b0;
    end else begin : g_local
      assign grp_hit[g] = |(events[g*MASK_W +: MASK_W] & mask);
    end
  end

  always_comb begin
    hit = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (sel == SEL_W'(g)) hit = grp_hit[g];
    end
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int NUM_GROUPS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         glb_en,
  input  logic [NUM_GROUPS*MASK_W-1:0] events,
  input  logic [LVL_W-1:0]             priv_lvl,
  input  logic                         kernel_mode,
  input  logic                         chain_in,
  input  logic                         wr_val,
  input  logic                         wr_ctl,
  input  logic                         wr_sta,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            value_q,
  output logic [DATA_W-1:0]            ctl_word,
  output logic [DATA_W-1:0]            sta_word,
  output logic                         wrap_o,
  output logic                         irq_bit
);
  ctl_t ctl_q;
  logic ovf_q, irq_q;
  logic ev_hit, trig, allow, bump;

  pmu_event_sel #(.NUM_GROUPS(NUM_GROUPS)) u_sel (
    .events (events),
    .sel    (ctl_q.sel),
    .mask   (ctl_q.mask),
    .hit    (ev_hit)
  );

  assign allow  = glb_en && (priv_lvl <= ctl_q.thresh) && (!kernel_mode || ctl_q.kern_ok);
  assign trig   = (ctl_q.sel == SEL_CHAIN) ? chain_in : ev_hit;
  assign bump   = allow && trig && !wr_val;
  assign wrap_o = bump && (value_q == {DATA_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_q <= '0;
      ctl_q   <= '0;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_val)    value_q <= wdata;
      else if (bump) value_q <= value_q + 32'd1;
      if (wr_ctl) ctl_q <= word_to_ctl(wdata);
      ovf_q <= wrap_o || (ovf_q && !(wr_sta && wdata[0]));
      irq_q <= (wrap_o && ctl_q.int_en) || (irq_q && !(wr_sta && wdata[4]));
    end
  end

  assign ctl_word = ctl_to_word(ctl_q);
  assign sta_word = {27'd0, irq_q, 3'd0, ovf_q};
  assign irq_bit  = irq_q;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !wr_val) |=> (value_q == $past(value_q))); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_val |=> (value_q == $past(value_q) || value_q == $past(value_q) + 32'd1)); // R4
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> (value_q == $past(wdata))); // R10
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> ovf_q); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(ctl_q.int_en)); // R6
endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter int NUM_CNT    = 8,
  parameter int NUM_GROUPS = 16,
  parameter int ADDR_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_we,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic [NUM_GROUPS*MASK_W-1:0] events_i,
  input  logic [LVL_W-1:0]             priv_lvl_i,
  input  logic                         kernel_mode_i,
  output logic                         irq_o
);
  localparam logic [ADDR_W-1:0] A_GLB = ADDR_W'(GLB_OFS);

  logic glb_q;
  logic [NUM_CNT-1:0] wr_val, wr_ctl, wr_sta, wrap, irq_bits;
  logic [NUM_CNT:0]   chain;
  logic [DATA_W-1:0]  val_w [NUM_CNT];
  logic [DATA_W-1:0]  ctl_w [NUM_CNT];
  logic [DATA_W-1:0]  sta_w [NUM_CNT];
  logic [NUM_CNT-1:0] hit_val, hit_ctl, hit_sta;
  logic sta_wr_any;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(VAL_BASE + 16'(4 * i));
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_BASE + 16'(4 * i));
    localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(STA_BASE + 16'(4 * i));

    assign hit_val[i] = (bus_addr == A_VAL);
    assign hit_ctl[i] = (bus_addr == A_CTL);
    assign hit_sta[i] = (bus_addr == A_STA);
    assign wr_val[i]  = bus_we && hit_val[i];
    assign wr_ctl[i]  = bus_we && hit_ctl[i];
    assign wr_sta[i]  = bus_we && hit_sta[i];

    pmu_counter #(.NUM_GROUPS(NUM_GROUPS)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .glb_en      (glb_q),
      .events      (events_i),
      .priv_lvl    (priv_lvl_i),
      .kernel_mode (kernel_mode_i),
      .chain_in    (chain[i]),
      .wr_val      (wr_val[i]),
      .wr_ctl      (wr_ctl[i]),
      .wr_sta      (wr_sta[i]),
      .wdata       (bus_wdata),
      .value_q     (val_w[i]),
      .ctl_word    (ctl_w[i]),
      .sta_word    (sta_w[i]),
      .wrap_o      (wrap[i]),
      .irq_bit     (irq_bits[i])
    );

    assign chain[i+1] = wrap[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           glb_q <= 1'b0;
    else if (bus_we && bus_addr == A_GLB) glb_q <= bus_wdata[0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_GLB) bus_rdata = {31'd0, glb_q};
    for (int i = 0; i < NUM_CNT; i++) begin
      if (hit_val[i]) bus_rdata = val_w[i];
      if (hit_ctl[i]) bus_rdata = ctl_w[i];
      if (hit_sta[i]) bus_rdata = sta_w[i];
    end
  end

  assign irq_o      = |irq_bits;
  assign sta_wr_any = |wr_sta;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !sta_wr_any) |=> irq_o); // R9
  AST_IRQ_QUIET_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !(|wrap)) |=> !irq_o); // R9
endmodule

// File: tb/tb_pmu_top.sv
`timescale 1ns/1ps
module tb_pmu_top;
  localparam int NC = 8;
  localparam int NG = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NG*16-1:0] events_i = '0;
  logic [3:0] priv_lvl_i = '0;
  logic kernel_mode_i = 1'b0;
  logic irq_o;

  always #4 clk = ~clk;

  pmu_top #(.NUM_CNT(NC), .NUM_GROUPS(NG), .ADDR_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .events_i(events_i),
    .priv_lvl_i(priv_lvl_i), .kernel_mode_i(kernel_mode_i), .irq_o(irq_o)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural model state
  logic [31:0] m_val [NC];
  logic [31:0] m_ctl [NC];
  bit          m_ovf [NC];
  bit          m_irq [NC];
  bit          m_glb;
  string       cur_tag = "R1 reset";

  function automatic logic [31:0] mread(input logic [15:0] a);
    if (a == 16'h1000) return {31'd0, m_glb};
    for (int i = 0; i < NC; i++) begin
      if (a == 16'h1080 + 16'(4*i)) return m_val[i];
      if (a == 16'h1100 + 16'(4*i)) return m_ctl[i];
      if (a == 16'h1180 + 16'(4*i)) return {27'd0, m_irq[i], 3'd0, m_ovf[i]};
    end
    return 32'd0;
  endfunction

  // advance model by one clock using the inputs the DUT just sampled
  task automatic model_step();
    bit prev_wrap = 0;
    for (int i = 0; i < NC; i++) begin
      int sel = int'(m_ctl[i][12:8]);
      logic [15:0] msk = m_ctl[i][31:16];
      bit trig, ok, inc, wr, wrapped;
      if (sel == 1) trig = (i > 0) && prev_wrap;
      else if (sel < NG) trig = |(events_i[sel*16 +: 16] & msk);
      else trig = 0;
      ok = m_glb && (priv_lvl_i <= m_ctl[i][7:4]) && (!kernel_mode_i || m_ctl[i][3]);
      wr = bus_we && (bus_addr == 16'h1080 + 16'(4*i));
      inc = ok && trig && !wr;
      wrapped = inc && (m_val[i] == 32'hFFFF_FFFF);
      if (bus_we && bus_addr == 16'h1180 + 16'(4*i)) begin
        if (bus_wdata[0]) m_ovf[i] = 0;
        if (bus_wdata[4]) m_irq[i] = 0;
      end
      if (wrapped) begin
        m_ovf[i] = 1;
        if (m_ctl[i][0]) m_irq[i] = 1;
      end
      if (wr) m_val[i] = bus_wdata;
      else if (inc) m_val[i] = m_val[i] + 32'd1;
      if (bus_we && bus_addr == 16'h1100 + 16'(4*i)) m_ctl[i] = bus_wdata & 32'hFFFF_1FF9;
      prev_wrap = wrapped;
    end
    if (bus_we && bus_addr == 16'h1000) m_glb = bus_wdata[0];
  endtask

  task automatic compare();
    bit m_any = 0;
    logic [31:0] exp_rd;
    for (int i = 0; i < NC; i++) m_any |= m_irq[i];
    exp_rd = mread(bus_addr);
    compared++;
    if (bus_rdata !== exp_rd) begin
      mismatched++;
      $display("FAIL %s: rdata @%h got %h expected %h", cur_tag, bus_addr, bus_rdata, exp_rd);
    end
    compared++;
    if (irq_o !== m_any) begin
      mismatched++;
      $display("FAIL R9 (%s): irq_o got %b expected %b", cur_tag, irq_o, m_any);
    end
  endtask

  // one clock: model follows the edge, then outputs are compared, then new inputs
  task automatic cyc(input logic [15:0] a, input bit we, input logic [31:0] wd, input string tag);
    @(negedge clk);
    model_step();
    compare();
    cur_tag = tag;
    bus_addr = a; bus_we = we; bus_wdata = wd;
  endtask

  task automatic rd(input logic [15:0] a, input string tag); cyc(a, 0, 32'd0, tag); endtask
  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag); cyc(a, 1, d, tag); endtask

  function automatic logic [15:0] va(input int i); return 16'h1080 + 16'(4*i); endfunction
  function automatic logic [15:0] ca(input int i); return 16'h1100 + 16'(4*i); endfunction
  function automatic logic [15:0] sa(input int i); return 16'h1180 + 16'(4*i); endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin m_val[i] = 0; m_ctl[i] = 0; m_ovf[i] = 0; m_irq[i] = 0; end
    m_glb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values and decode, including unmapped/misaligned
    rd(16'h1000, "R1 reset glb");
    for (int i = 0; i < NC; i++) begin
      rd(va(i), "R1 reset value"); rd(ca(i), "R1 reset ctrl"); rd(sa(i), "R1 reset status");
    end
    wr(16'h1004, 32'hFFFF_FFFF, "R1 unmapped write");
    rd(16'h1004, "R1 unmapped read");
    wr(16'h1082, 32'h1234_5678, "R1 misaligned write");
    rd(16'h1082, "R1 misaligned read");
    rd(va(0), "R1 misaligned ignored");

    // R3 control field layout
    wr(ca(0), 32'hFFFF_FFFF, "R3 ctrl write all ones");
    rd(ca(0), "R3 ctrl readback");
    wr(ca(0), 32'h0000_0000, "R11 ctrl zero");
    rd(ca(0), "R3 ctrl zero readback");

    // R2: counters configured, master enable off, events active
    events_i = '1;
    wr(ca(0), 32'hFFFF_02F9, "R2 ctrl0 group2");
    wr(va(0), 32'd5, "R2 preload");
    repeat (4) rd(va(0), "R2 held while disabled");
    wr(16'h1000, 32'hFFFF_FFFF, "R2 enable");
    rd(16'h1000, "R2 glb readback");
    repeat (4) rd(va(0), "R4 counting group2");

    // R4 mask selects bits; group beyond NUM_GROUPS never counts
    events_i = '0; events_i[3*16 +: 16] = 16'h0100;
    wr(ca(1), 32'h00FF_03F8, "R4 mask miss");
    repeat (3) rd(va(1), "R4 mask miss holds");
    wr(ca(1), 32'h0100_03F8, "R4 mask hit");
    repeat (3) rd(va(1), "R4 mask hit counts");
    wr(ca(1), 32'hFFFF_1FF8, "R4 out-of-range group");
    events_i = '1;
    repeat (3) rd(va(1), "R4 out-of-range no count");

    // R5 privilege threshold and kernel filter
    wr(ca(2), 32'hFFFF_0230, "R5 thresh3 no kernel");
    priv_lvl_i = 4'd5;
    repeat (3) rd(va(2), "R5 priv above threshold");
    priv_lvl_i = 4'd3;
    repeat (3) rd(va(2), "R5 priv at threshold");
    kernel_mode_i = 1'b1;
    repeat (3) rd(va(2), "R5 kernel blocked");
    wr(ca(2), 32'hFFFF_0238, "R5 kernel allowed");
    repeat (3) rd(va(2), "R5 kernel counts");
    kernel_mode_i = 1'b0; priv_lvl_i = 4'd0;

    // R6 R7: wrap with chaining, counter 3 chains on 2
    wr(ca(3), 32'h0000_01F9, "R7 chain ctrl");
    wr(ca(2), 32'hFFFF_02F9, "R6 ctrl2 inten");
    wr(va(3), 32'hFFFF_FFFE, "R7 chain preload");
    wr(va(2), 32'hFFFF_FFFD, "R6 preload near wrap");
    repeat (5) rd(va(3), "R7 chained count");
    rd(sa(2), "R6 status after wrap");
    rd(sa(3), "R6 chained wrap status");
    wr(ca(0), 32'hFFFF_01F9, "R7 counter0 chain select");
    repeat (3) rd(va(0), "R7 counter0 never counts");

    // R8 W1C; write of zero is no-op; coincident set wins
    wr(sa(2), 32'h0000_0000, "R8 write zero");
    rd(sa(2), "R8 zero write keeps");
    wr(sa(2), 32'h0000_0011, "R8 clear both");
    rd(sa(2), "R8 cleared");
    wr(va(2), 32'hFFFF_FFFE, "R8 preload");
    rd(va(2), "R8 step");
    wr(sa(2), 32'h0000_0011, "R8 clear coincides with wrap");
    rd(sa(2), "R8 set wins");
    wr(sa(3), 32'h0000_0011, "R8 clear ctr3");
    wr(sa(2), 32'h0000_0011, "R9 clear last irq");
    rd(sa(2), "R9 irq low");

    // R10 write wins over increment and over wrap
    wr(va(2), 32'hFFFF_FFFF, "R10 preload ffff_ffff");
    wr(va(2), 32'h0000_0010, "R10 write on wrap cycle");
    rd(va(2), "R10 written value");
    rd(sa(2), "R10 no wrap flag");

    // R11 all-zero control stops, value and status kept
    wr(va(4), 32'hFFFF_FFFF, "R11 preload");
    wr(ca(4), 32'hFFFF_02F1, "R11 run");
    rd(sa(4), "R11 wrapped");
    wr(ca(4), 32'h0, "R11 stop");
    repeat (4) rd(va(4), "R11 value kept");
    rd(sa(4), "R11 status kept");

    // random traffic, compared every cycle
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      int i  = $urandom_range(0, NC-1);
      logic [31:0] d = $urandom;
      for (int k = 0; k < NG/2; k++) events_i[k*32 +: 32] = $urandom & $urandom;
      priv_lvl_i = 4'($urandom_range(0, 15));
      kernel_mode_i = $urandom_range(0, 3) == 0;
      case (op)
        0: rd(va(i), "R4 random value read");
        1: rd(sa(i), "R6 random status read");
        2: rd(ca(i), "R3 random ctrl read");
        3: rd(va(i), "R7 random value read");
        4: wr(va(i), 32'hFFFF_FFF0 | (d & 32'hF), "R10 random preload");
        5: wr(sa(i), d & 32'h11, "R8 random clear");
        6: begin
          int s = $urandom_range(0, 5);
          logic [4:0] sv = (s == 0) ? 5'd0 : (s == 1) ? 5'd1 : (s == 2) ? 5'd2 :
                           (s == 3) ? 5'd3 : (s == 4) ? 5'd7 : 5'd31;
          wr(ca(i), {d[31:16], 3'b0, sv, d[7:0]}, "R5 random ctrl");
        end
        7: wr(16'h1000, {31'd0, $urandom_range(0, 9) != 0}, "R2 random enable");
        8: rd(16'h1004 + 16'(4*i), "R1 random unmapped");
        default: rd(16'h1000, "R2 random glb read");
      endcase
    end
    rd(16'h1000, "R1 final");
    @(negedge clk);
    model_step();
    compare();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule